// File: doc/BRIEF.md
# Hyperframe Sync and Pattern Checker

This block sits on the receive side of a link test path. It watches a parallel word bus and its control bits, one control bit per byte. It finds the synchronization word that opens each hyperframe and decides, through a small acquisition state machine, whether the receiver holds hyperframe sync. While sync is held, it checks every data word of the hyperframe against the expected incrementing pattern. It counts the cycles that mismatch, keeps a sticky error flag, and emits a one-cycle stop strobe on each hyperframe boundary for deterministic latency measurement.

The hyperframe length, measured in bus words, is `BASE_LEN << rate_sel`. With the defaults this gives 16, 32, 64 or 128 words. Setting `SIM_MODE` to 1 divides every length by four, to match a shortened transmit pattern. A sync word is a bus word whose control bits are `1` in bit 0 and `0` in all other bits, and whose low byte is `SYNC_CHAR` (0xBC by default). It is expected only at hyperframe position 0. Every other position k, for k = 1 to L-1, carries the value k zero-extended to the bus width, with all control bits zero.

The state machine has four states:
- HUNT: the block is searching. A sync word moves it to CONFIRM and restarts the position count at 1.
- CONFIRM: at each boundary, a sync word counts as a hit. Once `ACQ_N` hits are seen in a row, the block moves to LOCKED. A boundary without a sync word sends it back to HUNT. Sync words at other positions are ignored.
- LOCKED: a boundary without a sync word moves the block to FADING.
- FADING: a boundary sync word returns the block to LOCKED. The `LOSS_N`-th consecutive miss returns it to HUNT.

Top module: `hfc_checker`

## Requirements
- R1: While `rst_n` is low (asynchronously), `hf_sync`, `err_flag`, `stop_pulse` are 0 and `err_count` is 0, and the state machine is in HUNT.
- R2: The hyperframe length L is `BASE_LEN << rate_sel` words (16/32/64/128 by default). A sync word is a word with `rx_ctrl` = 1 (only bit 0 set) and `rx_data[7:0]` = 0xBC. While the block is acquiring, a sync word that does not fall a multiple of L words after the first one is ignored.
- R3: `hf_sync` goes high right after the clock edge that samples the second consecutive boundary sync word (`ACQ_N` = 2), the first one having been found in HUNT.
- R4: While `hf_sync` is low, no word is checked and `err_count` does not change.
- R5: While `hf_sync` is high, the word at position k (k = 1..L-1) must equal k zero-extended, with `rx_ctrl` = 0. Each word that differs, in data or in control, adds 1 to `err_count` at the edge that samples it.
- R6: `err_count` (5 bits) saturates at 31 and never wraps.
- R7: `err_flag` rises with the first counted error and stays high until reset.
- R8: With `LOSS_N` = 3, `hf_sync` stays high through one or two consecutive boundary words that are not sync words, and a sync word after them restores LOCKED. The third consecutive miss drops `hf_sync` right after its edge.
- R9: `stop_pulse` is high for exactly one cycle after the edge that samples a boundary sync word while `hf_sync` is high. It does not fire on the word that completes acquisition.
- R10: With `SIM_MODE` = 1, L is divided by 4 (4 words at `rate_sel` = 0), and acquisition follows that spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rate_sel | input | RATE_W | Rate code, selects hyperframe length |
| rx_data | input | DATA_W | Received data word |
| rx_ctrl | input | DATA_W/8 | Received control bits, one per byte |
| hf_sync | output | 1 | Hyperframe sync held |
| err_flag | output | 1 | Sticky: at least one mismatch counted |
| err_count | output | ERR_W | Saturating count of mismatched cycles |
| stop_pulse | output | 1 | One-cycle latency stop strobe |

## Verification
The assertions take it that `rate_sel` is constant outside reset. They also take it that every hyperframe has at least two words, so that two boundary sync words can never fall on adjacent cycles. The bench changes `rate_sel` only while `rst_n` is low, and the shortest hyperframe it uses has 4 words. It drives all inputs on the falling clock edge, so each word is sampled cleanly at a single rising edge.

// File: rtl/hfc_pkg.sv
package hfc_pkg;
    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_LOCKED  = 2'd2,
        ST_FADING  = 2'd3
    } hfc_state_e;
endpackage

// File: rtl/hfc_sync_detect.sv
module hfc_sync_detect #(
    parameter int DATA_W    = 16,
    parameter logic [7:0] SYNC_CHAR = 8'hBC,
    localparam int BYTES    = DATA_W / 8
) (
    input  logic [DATA_W-1:0] rx_data,
    input  logic [BYTES-1:0]  rx_ctrl,
    output logic              sync_seen
);
    always_comb begin
        sync_seen = (rx_ctrl == BYTES'(1)) && (rx_data[7:0] == SYNC_CHAR);
    end
endmodule

// File: rtl/hfc_sync_fsm.sv
module hfc_sync_fsm
    import hfc_pkg::*;
#(
    parameter int RATE_W   = 2,
    parameter int BASE_LEN = 16,
    parameter bit SIM_MODE = 1'b0,
    parameter int ACQ_N    = 2,
    parameter int LOSS_N   = 3,
    localparam int MAX_LEN = BASE_LEN << ((1 << RATE_W) - 1),
    localparam int POS_W   = $clog2(MAX_LEN),
    localparam int LEN_W   = POS_W + 1,
    localparam int SHIFT   = SIM_MODE ? 2 : 0,
    localparam int CNT_MAX = (ACQ_N > LOSS_N) ? ACQ_N : LOSS_N,
    localparam int CNT_W   = $clog2(CNT_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              sync_seen,
    output logic [POS_W-1:0]  pos,
    output logic              at_bnd,
    output logic              in_sync
);
    hfc_state_e       st_q, st_d;
    logic [POS_W-1:0] pos_q, pos_d, last_idx;
    logic [CNT_W-1:0] hit_q, hit_d, miss_q, miss_d;
    logic [LEN_W-1:0] len_w;
    logic             bnd;

    always_comb begin
        len_w    = (LEN_W'(BASE_LEN) << rate_sel) >> SHIFT;
        last_idx = POS_W'(len_w - LEN_W'(1));
        bnd      = (pos_q == '0);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_HUNT;
            pos_q  <= '0;
            hit_q  <= '0;
            miss_q <= '0;
        end else begin
            st_q   <= st_d;
            pos_q  <= pos_d;
            hit_q  <= hit_d;
            miss_q <= miss_d;
        end
    end

    // next state
    always_comb begin
        st_d   = st_q;
        pos_d  = (pos_q == last_idx) ? '0 : pos_q + POS_W'(1);
        hit_d  = hit_q;
        miss_d = miss_q;
        unique case (st_q)
            ST_HUNT: begin
                pos_d = '0;
                if (sync_seen) begin
                    pos_d = POS_W'(1);
                    hit_d = CNT_W'(1);
                    st_d  = (ACQ_N <= 1) ? ST_LOCKED : ST_CONFIRM;
                end
            end
            ST_CONFIRM: begin
                if (bnd) begin
                    if (!sync_seen) begin
                        st_d  = ST_HUNT;
                        pos_d = '0;
                    end else if (hit_q == CNT_W'(ACQ_N - 1)) begin
                        st_d   = ST_LOCKED;
                        miss_d = '0;
                    end else begin
                        hit_d = hit_q + CNT_W'(1);
                    end
                end
            end
            ST_LOCKED: begin
                if (bnd && !sync_seen) begin
                    miss_d = CNT_W'(1);
                    if (LOSS_N <= 1) begin
                        st_d  = ST_HUNT;
                        pos_d = '0;
                    end else begin
                        st_d = ST_FADING;
                    end
                end
            end
            ST_FADING: begin
                if (bnd) begin
                    if (sync_seen) begin
                        st_d   = ST_LOCKED;
                        miss_d = '0;
                    end else if (miss_q == CNT_W'(LOSS_N - 1)) begin
                        st_d  = ST_HUNT;
                        pos_d = '0;
                    end else begin
                        miss_d = miss_q + CNT_W'(1);
                    end
                end
            end
            default: st_d = ST_HUNT;
        endcase
    end

    // outputs
    always_comb begin
        pos     = pos_q;
        at_bnd  = bnd && (st_q != ST_HUNT);
        in_sync = (st_q == ST_LOCKED) || (st_q == ST_FADING);
    end
endmodule

// File: rtl/hfc_err_accum.sv
module hfc_err_accum #(
    parameter int DATA_W = 16,
    parameter int POS_W  = 7,
    parameter int ERR_W  = 5,
    localparam int BYTES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              check_en,
    input  logic [POS_W-1:0]  pos,
    input  logic [DATA_W-1:0] rx_data,
    input  logic [BYTES-1:0]  rx_ctrl,
    output logic [ERR_W-1:0]  err_count,
    output logic              err_flag
);
    logic [DATA_W-1:0] expect_w;
    logic              mismatch;
    logic [ERR_W-1:0]  cnt_q;
    logic              flag_q;

    always_comb begin
        expect_w = DATA_W'(pos);
        mismatch = check_en && ((rx_data != expect_w) || (rx_ctrl != '0));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else if (mismatch) begin
            flag_q <= 1'b1;
            if (cnt_q != '1) begin
                cnt_q <= cnt_q + ERR_W'(1);
            end
        end
    end

    assign err_count = cnt_q;
    assign err_flag  = flag_q;
endmodule

// File: rtl/hfc_checker.sv
module hfc_checker #(
    parameter int DATA_W   = 16,
    parameter int RATE_W   = 2,
    parameter int BASE_LEN = 16,
    parameter bit SIM_MODE = 1'b0,
    parameter int ACQ_N    = 2,
    parameter int LOSS_N   = 3,
    parameter int ERR_W    = 5,
    parameter logic [7:0] SYNC_CHAR = 8'hBC,
    localparam int BYTES   = DATA_W / 8,
    localparam int MAX_LEN = BASE_LEN << ((1 << RATE_W) - 1),
    localparam int POS_W   = $clog2(MAX_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic [DATA_W-1:0] rx_data,
    input  logic [BYTES-1:0]  rx_ctrl,
    output logic              hf_sync,
    output logic              err_flag,
    output logic [ERR_W-1:0]  err_count,
    output logic              stop_pulse
);
    logic             sync_seen;
    logic [POS_W-1:0] pos;
    logic             at_bnd;
    logic             in_sync;
    logic             stop_q;

    hfc_sync_detect #(
        .DATA_W(DATA_W), .SYNC_CHAR(SYNC_CHAR)
    ) u_detect (
        .rx_data(rx_data), .rx_ctrl(rx_ctrl), .sync_seen(sync_seen)
    );

    hfc_sync_fsm #(
        .RATE_W(RATE_W), .BASE_LEN(BASE_LEN), .SIM_MODE(SIM_MODE),
        .ACQ_N(ACQ_N), .LOSS_N(LOSS_N)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .sync_seen(sync_seen),
        .pos(pos), .at_bnd(at_bnd), .in_sync(in_sync)
    );

    hfc_err_accum #(
        .DATA_W(DATA_W), .POS_W(POS_W), .ERR_W(ERR_W)
    ) u_err (
        .clk(clk), .rst_n(rst_n), .check_en(in_sync && !at_bnd), .pos(pos),
        .rx_data(rx_data), .rx_ctrl(rx_ctrl),
        .err_count(err_count), .err_flag(err_flag)
    );

    // latency stop strobe on each in-sync boundary sync word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stop_q <= 1'b0;
        end else begin
            stop_q <= in_sync && at_bnd && sync_seen;
        end
    end

    assign hf_sync    = in_sync;
    assign stop_pulse = stop_q;
endmodule

// File: rtl/hfc_checker_sva.sv
module hfc_checker_sva #(
    parameter int ERR_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hf_sync,
    input logic             err_flag,
    input logic [ERR_W-1:0] err_count,
    input logic             stop_pulse
);
    // R6
    p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count == '1) |=> (err_count == '1));

    // R5
    p_step_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((err_count == $past(err_count)) ||
                  (err_count == $past(err_count) + ERR_W'(1))));

    // R7
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    // R7
    p_flag_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag == (err_count != '0));

    // R4
    p_quiet_unsync_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !hf_sync |=> (err_count == $past(err_count)));

    // R9
    p_stop_in_sync_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |-> $past(hf_sync));

    // R9
    p_stop_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |=> !stop_pulse);
endmodule

bind hfc_checker hfc_checker_sva #(.ERR_W(ERR_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .hf_sync(hf_sync), .err_flag(err_flag),
    .err_count(err_count), .stop_pulse(stop_pulse)
);

// File: tb/hfc_checker_tb_top.sv
module hfc_checker_tb_top;
    localparam int DW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  rate_sel = 2'd0;
    logic [DW-1:0] rx_data = '0;
    logic [1:0]  rx_ctrl = '0;
    logic        hf_sync, err_flag, stop_pulse;
    logic [4:0]  err_count;

    logic [1:0]  s_rate = 2'd0;
    logic [DW-1:0] s_data = '0;
    logic [1:0]  s_ctrl = '0;
    logic        s_sync, s_flag, s_stop;
    logic [4:0]  s_count;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;

    hfc_checker dut_i (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .rx_data(rx_data),
        .rx_ctrl(rx_ctrl), .hf_sync(hf_sync), .err_flag(err_flag),
        .err_count(err_count), .stop_pulse(stop_pulse)
    );

    hfc_checker #(.SIM_MODE(1'b1)) dut_s (
        .clk(clk), .rst_n(rst_n), .rate_sel(s_rate), .rx_data(s_data),
        .rx_ctrl(s_ctrl), .hf_sync(s_sync), .err_flag(s_flag),
        .err_count(s_count), .stop_pulse(s_stop)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog: act=%0d cycles exp<=100000", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(input string req, input string what,
                         input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    // one word to the main checker, result visible on return
    task automatic send(input logic [DW-1:0] d, input logic [1:0] c);
        @(negedge clk);
        rx_data = d;
        rx_ctrl = c;
        @(posedge clk);
        #1;
    endtask

    task automatic send_s(input logic [DW-1:0] d, input logic [1:0] c);
        @(negedge clk);
        s_data = d;
        s_ctrl = c;
        @(posedge clk);
        #1;
    endtask

    task automatic sync_word(input bit ok);
        if (ok) send(16'h00BC, 2'b01);
        else    send(16'h0000, 2'b00);
    endtask

    // positions lo..hi; those in bad_lo..bad_hi carry a wrong value
    task automatic data_words(input int lo, input int hi,
                              input int bad_lo, input int bad_hi);
        for (int k = lo; k <= hi; k++) begin
            if (k >= bad_lo && k <= bad_hi) send(~DW'(k), 2'b00);
            else                            send(DW'(k), 2'b00);
        end
    endtask

    task automatic do_reset(input logic [1:0] rate);
        @(negedge clk);
        rst_n = 1'b0;
        rate_sel = rate;
        rx_data = '0;
        rx_ctrl = '0;
        #1;
        check("R1", "hf_sync in reset", int'(hf_sync), 0);
        check("R1", "err_count in reset", int'(err_count), 0);
        check("R1", "err_flag in reset", int'(err_flag), 0);
        check("R1", "stop in reset", int'(stop_pulse), 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_sim_mode();
        // R10: SIM_MODE shrinks hyperframe to 4 words at rate 0
        send_s(16'h00BC, 2'b01);
        check("R10", "sim not yet synced", int'(s_sync), 0);
        for (int k = 1; k < 4; k++) send_s(DW'(k), 2'b00);
        send_s(16'h00BC, 2'b01);
        check("R10", "sim synced after 4-word spacing", int'(s_sync), 1);
        for (int k = 1; k < 4; k++) send_s(DW'(k), 2'b00);
        send_s(16'h00BC, 2'b01);
        check("R10", "sim stop on boundary", int'(s_stop), 1);
        check("R10", "sim no errors", int'(s_count), 0);
        check("R4", "main idle unsynced", int'(hf_sync), 0);
    endtask

    task automatic t_acquire();
        for (int k = 0; k < 5; k++) send(16'hFFFF, 2'b00);
        check("R3", "no sync on junk", int'(hf_sync), 0);
        sync_word(1'b1);
        check("R3", "one sync word not enough", int'(hf_sync), 0);
        data_words(1, 4, 2, 3);
        sync_word(1'b1);            // position 5: off boundary
        check("R2", "off-boundary sync ignored", int'(hf_sync), 0);
        data_words(6, 15, 8, 8);
        check("R4", "no count before sync", int'(err_count), 0);
        sync_word(1'b1);
        check("R3", "sync after second boundary", int'(hf_sync), 1);
        check("R9", "no stop on acquiring word", int'(stop_pulse), 0);
        data_words(1, 15, 0, -1);
        check("R5", "clean frame no errors", int'(err_count), 0);
        sync_word(1'b1);
        check("R9", "stop on in-sync boundary", int'(stop_pulse), 1);
        data_words(1, 1, 0, -1);
        check("R9", "stop lasts one cycle", int'(stop_pulse), 0);
        data_words(2, 15, 0, -1);
    endtask

    task automatic t_errors();
        sync_word(1'b1);
        data_words(1, 3, 3, 3);
        check("R5", "first mismatch counted", int'(err_count), 1);
        check("R7", "flag rises", int'(err_flag), 1);
        data_words(4, 6, 0, -1);
        send(DW'(7), 2'b10);        // right data, wrong control
        check("R5", "control mismatch counted", int'(err_count), 2);
        data_words(8, 15, 9, 9);
        check("R5", "three mismatches", int'(err_count), 3);
    endtask

    task automatic t_loss();
        sync_word(1'b0);
        check("R8", "held after 1 miss", int'(hf_sync), 1);
        check("R9", "no stop on miss", int'(stop_pulse), 0);
        data_words(1, 15, 0, -1);
        sync_word(1'b0);
        check("R8", "held after 2 misses", int'(hf_sync), 1);
        data_words(1, 15, 0, -1);
        sync_word(1'b1);
        check("R8", "restored by sync", int'(hf_sync), 1);
        check("R9", "stop after recovery", int'(stop_pulse), 1);
        data_words(1, 15, 0, -1);
        sync_word(1'b0);
        data_words(1, 15, 0, -1);
        sync_word(1'b0);
        data_words(1, 15, 0, -1);
        check("R8", "held before third miss", int'(hf_sync), 1);
        sync_word(1'b0);
        check("R8", "dropped on third miss", int'(hf_sync), 0);
        data_words(1, 15, 4, 6);
        check("R4", "unsynced words not counted", int'(err_count), 3);
        check("R7", "flag still set", int'(err_flag), 1);
    endtask

    task automatic t_saturate();
        sync_word(1'b1);
        data_words(1, 15, 0, -1);
        sync_word(1'b1);
        check("R3", "reacquired", int'(hf_sync), 1);
        data_words(1, 15, 1, 15);
        check("R5", "count after 15 bad words", int'(err_count), 18);
        sync_word(1'b1);
        data_words(1, 15, 1, 15);
        check("R6", "saturates at 31", int'(err_count), 31);
        sync_word(1'b1);
        data_words(1, 15, 1, 15);
        check("R6", "stays at 31", int'(err_count), 31);
    endtask

    task automatic t_rate();
        check("R7", "flag cleared by reset", int'(err_flag), 0);
        sync_word(1'b1);
        data_words(1, 15, 0, -1);
        sync_word(1'b1);            // position 16: not a rate-2 boundary
        check("R2", "16-word spacing rejected at rate 2", int'(hf_sync), 0);
        data_words(17, 63, 0, -1);
        sync_word(1'b1);
        check("R2", "64-word spacing locks at rate 2", int'(hf_sync), 1);
        data_words(1, 63, 40, 40);
        check("R5", "rate 2 position check", int'(err_count), 1);
    endtask

    initial begin
        do_reset(2'd0);
        t_sim_mode();
        do_reset(2'd0);
        t_acquire();
        t_errors();
        t_loss();
        t_saturate();
        do_reset(2'd2);
        t_rate();
        summary();
        $finish;
    end
endmodule